// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block maps memory for an 8-bit console cartridge. The CPU sees one 32 KB program ROM bank in its upper half. The video side sees two 4 KB character ROM banks, one for each half of its pattern space. Three write-only bank registers sit on the top three bytes of the 8 KB work-RAM window at CPU $6000-$7FFF. A write to one of those bytes loads the register and also goes through to the RAM at the same address. A read of those bytes returns RAM contents, so the block drives no CPU read data.

A CPU write is accepted by a two-state commit machine. In `BUS_IDLE`, a valid write that decodes to a register moves it to `BUS_HOLD` (transition *arm*). It stays in `BUS_HOLD` while the CPU cycle continues, following the data bus (transition *track*). When `cpu_valid` drops, it loads the selected register and returns to `BUS_IDLE` (transition *commit*). Every other cycle stays in `BUS_IDLE` (transition *idle*). The character bank number is picked for each fetch by video address bit 12. Nametable mirroring is a fixed horizontal setting.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous reset, the program bank and both character bank registers are zero.
- R2: A completed write to $7FFD loads the program bank from the low PRG_BITS data bits. `prg_rom_addr` equals {program bank, cpu_addr[14:0]}.
- R3: A completed write to $7FFE loads character register 0 from the low CHR_BITS data bits.
- R4: A completed write to $7FFF loads character register 1 from the low CHR_BITS data bits.
- R5: `chr_rom_addr` equals {bank, ppu_addr[11:0]}. The bank is character register 0 when ppu_addr[12] is 0, and register 1 when it is 1.
- R6: A write to $7FFC (address bits 1:0 equal to 00) leaves all three registers unchanged.
- R7: Reads, writes with `wram_en` low, and writes in the window whose address bits 12 to 2 are not all ones leave all registers unchanged.
- R8: `ram_cs` is high whenever `wram_en` is high and cpu_addr[15:13] is 011. `ram_we` is high when `ram_cs`, `cpu_valid` and write (`cpu_rw` = 0) are all high, including writes to register addresses.
- R9: `mirror_h` is constantly 1, meaning horizontal mirroring.
- R10: A register keeps its old value while `cpu_valid` stays high. It takes the new value on the first clock edge at which `cpu_valid` is low after the write was armed.
- R11: Data bits above the register width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_valid | input | 1 | CPU bus cycle active |
| wram_en | input | 1 | Work-RAM window enable |
| ppu_addr | input | 13 | Video pattern address |
| prg_rom_addr | output | PRG_BITS+15 | Program ROM address |
| chr_rom_addr | output | CHR_BITS+12 | Character ROM address |
| ram_cs | output | 1 | Work-RAM chip select |
| ram_we | output | 1 | Work-RAM write enable |
| mirror_h | output | 1 | Horizontal mirroring flag |

## Verification
The bench builds the block with its default widths: a 1-bit program bank and 4-bit character banks. With these narrow registers, the data bits above the register width are easy to drive as ones and show that they are dropped. All sixteen character bank values and both program banks are reachable with short write sequences. The wider 8-bit build changes only slice widths and is not exercised separately.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_PRG  = 2'b01,
        SEL_CHR0 = 2'b10,
        SEL_CHR1 = 2'b11
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HOLD = 1'b1
    } bus_state_e;
endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
    import mapper_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    input  logic        cpu_valid,
    input  logic        wram_en,
    output logic        ram_cs,
    output logic        ram_we,
    output reg_sel_e    reg_sel
);
    logic in_window;
    logic top_bytes;

    always_comb begin
        in_window = wram_en && (cpu_addr[15:13] == 3'b011);
        top_bytes = &cpu_addr[12:2];
        ram_cs    = in_window;
        ram_we    = in_window && cpu_valid && !cpu_rw;
        reg_sel   = SEL_NONE;
        if (in_window && !cpu_rw && top_bytes) begin
            unique case (cpu_addr[1:0])
                2'b01:   reg_sel = SEL_PRG;
                2'b10:   reg_sel = SEL_CHR0;
                2'b11:   reg_sel = SEL_CHR1;
                default: reg_sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mapper_commit_fsm.sv
module mapper_commit_fsm
    import mapper_pkg::*;
#(
    parameter int PRG_BITS = 1,
    parameter int CHR_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_valid,
    input  reg_sel_e            reg_sel,
    input  logic [7:0]          cpu_data,
    output logic [PRG_BITS-1:0] prg_bank,
    output logic [CHR_BITS-1:0] chr_bank0,
    output logic [CHR_BITS-1:0] chr_bank1
);
    localparam int DATA_W = (PRG_BITS > CHR_BITS) ? PRG_BITS : CHR_BITS;

    bus_state_e          state, state_nx;
    reg_sel_e            pend_sel;
    logic [DATA_W-1:0]   pend_data;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: if (cpu_valid && reg_sel != SEL_NONE) state_nx = BUS_HOLD;
            BUS_HOLD: if (!cpu_valid) state_nx = BUS_IDLE;
            default:  state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_sel  <= SEL_NONE;
            pend_data <= '0;
            prg_bank  <= '0;
            chr_bank0 <= '0;
            chr_bank1 <= '0;
        end else begin
            unique case (state)
                BUS_IDLE: begin
                    if (cpu_valid && reg_sel != SEL_NONE) begin
                        pend_sel  <= reg_sel;
                        pend_data <= cpu_data[DATA_W-1:0];
                    end
                end
                BUS_HOLD: begin
                    if (cpu_valid) begin
                        pend_data <= cpu_data[DATA_W-1:0];
                    end else begin
                        unique case (pend_sel)
                            SEL_PRG:  prg_bank  <= pend_data[PRG_BITS-1:0];
                            SEL_CHR0: chr_bank0 <= pend_data[CHR_BITS-1:0];
                            SEL_CHR1: chr_bank1 <= pend_data[CHR_BITS-1:0];
                            default:  ;
                        endcase
                        pend_sel <= SEL_NONE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mapper_chr_mux.sv
module mapper_chr_mux #(
    parameter int CHR_BITS = 4
) (
    input  logic                ppu_a12,
    input  logic [CHR_BITS-1:0] chr_bank0,
    input  logic [CHR_BITS-1:0] chr_bank1,
    output logic [CHR_BITS-1:0] chr_bank
);
    for (genvar b = 0; b < CHR_BITS; b++) begin : g_bit
        assign chr_bank[b] = ppu_a12 ? chr_bank1[b] : chr_bank0[b];
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BITS = 1,
    parameter int CHR_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_data,
    input  logic                     cpu_rw,
    input  logic                     cpu_valid,
    input  logic                     wram_en,
    input  logic [12:0]              ppu_addr,
    output logic [PRG_BITS+14:0]     prg_rom_addr,
    output logic [CHR_BITS+11:0]     chr_rom_addr,
    output logic                     ram_cs,
    output logic                     ram_we,
    output logic                     mirror_h
);
    reg_sel_e            reg_sel;
    logic [PRG_BITS-1:0] prg_bank;
    logic [CHR_BITS-1:0] chr_bank0, chr_bank1, chr_bank;

    mapper_decode u_decode (
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .cpu_valid (cpu_valid),
        .wram_en   (wram_en),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .reg_sel   (reg_sel)
    );

    mapper_commit_fsm #(.PRG_BITS(PRG_BITS), .CHR_BITS(CHR_BITS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .reg_sel   (reg_sel),
        .cpu_data  (cpu_data),
        .prg_bank  (prg_bank),
        .chr_bank0 (chr_bank0),
        .chr_bank1 (chr_bank1)
    );

    mapper_chr_mux #(.CHR_BITS(CHR_BITS)) u_mux (
        .ppu_a12   (ppu_addr[12]),
        .chr_bank0 (chr_bank0),
        .chr_bank1 (chr_bank1),
        .chr_bank  (chr_bank)
    );

    always_comb begin
        prg_rom_addr = {prg_bank, cpu_addr[14:0]};
        chr_rom_addr = {chr_bank, ppu_addr[11:0]};
        mirror_h     = 1'b1;
    end
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int PRG_BITS = 1,
    parameter int CHR_BITS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cpu_valid,
    input logic [12:0]          ppu_addr,
    input logic [PRG_BITS+14:0] prg_rom_addr,
    input logic [CHR_BITS+11:0] chr_rom_addr,
    input logic                 ram_cs,
    input logic                 ram_we
);
    wire [PRG_BITS-1:0] prg_top = prg_rom_addr[PRG_BITS+14:15];
    wire [CHR_BITS-1:0] chr_top = chr_rom_addr[CHR_BITS+11:12];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prg_top == '0 && chr_top == '0)); // R1

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_cs); // R8

    AST_PRG_WAITS_CYCLE_END: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpu_valid)) |-> $stable(prg_top)); // R10

    AST_CHR_STEADY_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpu_valid) && $stable(ppu_addr[12])) |-> $stable(chr_top)); // R5
endmodule

bind cart_bank_mapper mapper_checker #(.PRG_BITS(PRG_BITS), .CHR_BITS(CHR_BITS)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_valid    (cpu_valid),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .chr_rom_addr (chr_rom_addr),
    .ram_cs       (ram_cs),
    .ram_we       (ram_we)
);

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        wram_en = 1'b0;
    logic [12:0] ppu_addr = 13'h0000;
    logic [15:0] prg_rom_addr;
    logic [15:0] chr_rom_addr;
    logic        ram_cs, ram_we, mirror_h;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cart_bank_mapper i_cart_bank_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_valid(cpu_valid), .wram_en(wram_en),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_rom_addr(chr_rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .mirror_h(mirror_h)
    );

    // [31:16] addr [15:8] data [7] rw [6] en [5] a12 [4] exp prg [3:0] exp chr
    localparam logic [31:0] VEC [0:10] = '{
        {16'h7FFD, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0},  // R2
        {16'h7FFE, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 4'h5},  // R3 R11
        {16'h7FFF, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 4'hC},  // R4 R5
        {16'h7FFC, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 4'h5},  // R6
        {16'h7FFD, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 4'hC},  // R7 read
        {16'h7FFD, 8'hFE, 1'b0, 1'b1, 1'b0, 1'b0, 4'h5},  // R2 R11
        {16'h7FFE, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5},  // R7 disabled
        {16'h6FFE, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 4'h5},  // R7 A12 low
        {16'h7FBE, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 4'h5},  // R7 A6 low
        {16'h7FFE, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9},  // R3
        {16'h7FFF, 8'hF2, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2}   // R4 R5 R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic en);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; wram_en = en; cpu_valid = 1'b1;
        #1;
        chk("R8 ram_we", {31'd0, ram_we}, {31'd0, en && !rw});
        @(negedge clk);
        cpu_valid = 1'b0;
        @(negedge clk);
        cpu_rw = 1'b1; wram_en = 1'b0;
    endtask

    task automatic look(input string req, input logic a12, input logic p, input logic [3:0] c);
        cpu_addr = 16'hC123;
        ppu_addr = {a12, 12'hABC};
        #1;
        chk({req, " prg"}, {16'd0, prg_rom_addr}, {16'd0, p, 15'h4123});
        chk({req, " chr"}, {16'd0, chr_rom_addr}, {16'd0, c, 12'hABC});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        look("R1 reset a12=0", 1'b0, 1'b0, 4'h0);
        look("R1 reset a12=1", 1'b1, 1'b0, 4'h0);
        chk("R9 mirror", {31'd0, mirror_h}, 32'd1);

        for (int i = 0; i < 11; i++) begin
            bus_cycle(VEC[i][31:16], VEC[i][15:8], VEC[i][7], VEC[i][6]);
            look($sformatf("R2-vec%0d", i), VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end
        look("R5 a12=0 picks reg0", 1'b0, 1'b0, 4'h9);

        // R8: chip select follows the window, write enable needs valid
        @(negedge clk);
        cpu_addr = 16'h6010; wram_en = 1'b1; cpu_rw = 1'b0; cpu_valid = 1'b0; #1;
        chk("R8 cs in window", {30'd0, ram_cs, ram_we}, 32'd2);
        cpu_addr = 16'h8010; #1;
        chk("R8 cs outside window", {30'd0, ram_cs, ram_we}, 32'd0);
        wram_en = 1'b0; cpu_rw = 1'b1;

        // R10: value held while cycle stays valid
        @(negedge clk);
        cpu_addr = 16'h7FFD; cpu_data = 8'h01; cpu_rw = 1'b0; wram_en = 1'b1; cpu_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 hold", {31'd0, prg_rom_addr[15]}, 32'd0);
        end
        cpu_valid = 1'b0;
        @(negedge clk);
        chk("R10 commit", {31'd0, prg_rom_addr[15]}, 32'd1);
        cpu_rw = 1'b1; wram_en = 1'b0;

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        look("R1 mid reset", 1'b1, 1'b0, 4'h0);
        chk("R9 mirror after reset", {31'd0, mirror_h}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule